// File: doc/BRIEF.md
# Segmented I/O Address Router

This block sits between a host bus and a set of downstream I/O buses and decides where each I/O-space access goes. The 16-bit I/O space is cut into sixteen 4 KB segments. The top address nibble selects a segment, and a per-segment route register names the target bus. Software loads the route registers through a small synchronous write/read port.

Segment 0 is tied to the single legacy compatibility bus, and writes to its route register have no effect. The block also decides whether a write may be posted. A global posting enable allows posting of writes. Any access below 0x100 is always deferred, even when posting is enabled. Reads are never posted.

Each request is presented with a valid strobe. The route and posting decision appear on registered outputs one clock later.

Top module: `io_seg_router`

## Requirements
- R1: After reset, every segment's route reads back as the legacy bus (index 0), and `rsp_valid_o` is low.
- R2: The segment is `req_addr_i[15:12]`. For segments 1 to 15, `rsp_bus_o` equals the last value written to that segment's route register. The offset bits `[11:0]` do not affect routing, so 0x0FFF lands in segment 0 and 0x1000 lands in segment 1.
- R3: Segment 0 always routes to the legacy bus. A configuration write with `cfg_sel_i` = 0 changes neither the routing nor the value read back, which stays 0.
- R4: A request with an address below 0x100 yields `rsp_posted_o` = 0, whatever `post_en_i` and `req_write_i` are. 0x00FF is deferred.
- R5: A write (`req_write_i` = 1) at an address of 0x100 or above yields `rsp_posted_o` equal to `post_en_i`. 0x0100 posts when posting is enabled.
- R6: A read (`req_write_i` = 0) always yields `rsp_posted_o` = 0.
- R7: `rsp_valid_o` is high in the cycle after a cycle with `req_valid_i` high, and low otherwise. When it is low, `rsp_bus_o` and `rsp_posted_o` are 0.
- R8: A route write takes effect for requests presented in the following cycle. A request presented in the same cycle as the write uses the old route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Route register write strobe |
| cfg_sel_i | input | 4 | Segment select for write and read |
| cfg_wdata_i | input | BUS_W | Route value to write |
| cfg_rdata_o | output | BUS_W | Route of the selected segment |
| post_en_i | input | 1 | Global write posting enable |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 16 | I/O address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| rsp_valid_o | output | 1 | Decode result valid |
| rsp_bus_o | output | BUS_W | Target bus index |
| rsp_posted_o | output | 1 | Access may be posted |

## Verification
A corrupted route register misroutes the first request that hits its segment. It also shows on `cfg_rdata_o` as soon as that segment is selected, with no extra cycle. A wrong posting decision appears on `rsp_posted_o` in the cycle after the request. Boundary addresses are exercised so that an off-by-one in the defer window or in the segment slice shows at once. Back-to-back write and request cycles expose a route that takes effect one cycle early or late.

// File: rtl/io_route_pkg.sv
package io_route_pkg;
  localparam int unsigned IO_ADDR_W = 16;
  localparam int unsigned SEG_SEL_W = 4;
  localparam int unsigned NUM_SEG   = 1 << SEG_SEL_W;
  localparam logic [IO_ADDR_W-1:0] DEFER_TOP = 16'h0100;

  function automatic logic [SEG_SEL_W-1:0] seg_of(input logic [IO_ADDR_W-1:0] a);
    return a[IO_ADDR_W-1 -: SEG_SEL_W];
  endfunction
endpackage

// File: rtl/io_route_cfg.sv
module io_route_cfg
  import io_route_pkg::*;
#(
  parameter int unsigned BUS_W      = 2,
  parameter int unsigned LEGACY_BUS = 0
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [SEG_SEL_W-1:0]            sel_i,
  input  logic [BUS_W-1:0]                wdata_i,
  output logic [BUS_W-1:0]                rdata_o,
  output logic [NUM_SEG-1:0][BUS_W-1:0]   routes_o
);
  localparam logic [BUS_W-1:0] LEGACY = BUS_W'(LEGACY_BUS);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    if (s == 0) begin : g_fixed
      // legacy segment: no storage, writes dropped
      assign routes_o[s] = LEGACY;
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     routes_o[s] <= LEGACY;
        else if (we_i && sel_i == SEG_SEL_W'(s))         routes_o[s] <= wdata_i;
      end
    end
  end

  assign rdata_o = routes_o[sel_i];
endmodule

// File: rtl/io_route_decode.sv
module io_route_decode
  import io_route_pkg::*;
#(
  parameter int unsigned BUS_W = 2
) (
  input  logic [IO_ADDR_W-1:0]            addr_i,
  input  logic                            write_i,
  input  logic                            post_en_i,
  input  logic [NUM_SEG-1:0][BUS_W-1:0]   routes_i,
  output logic [BUS_W-1:0]                bus_o,
  output logic                            posted_o
);
  logic defer_only;

  always_comb begin
    bus_o      = routes_i[seg_of(addr_i)];
    defer_only = addr_i < DEFER_TOP;
    // defer window overrides the global enable
    posted_o   = write_i && post_en_i && !defer_only;
  end
endmodule

// File: rtl/io_seg_router.sv
module io_seg_router
  import io_route_pkg::*;
#(
  parameter int unsigned NUM_BUS    = 4,
  parameter int unsigned LEGACY_BUS = 0,
  localparam int unsigned BUS_W     = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [SEG_SEL_W-1:0]  cfg_sel_i,
  input  logic [BUS_W-1:0]      cfg_wdata_i,
  output logic [BUS_W-1:0]      cfg_rdata_o,
  input  logic                  post_en_i,
  input  logic                  req_valid_i,
  input  logic [IO_ADDR_W-1:0]  req_addr_i,
  input  logic                  req_write_i,
  output logic                  rsp_valid_o,
  output logic [BUS_W-1:0]      rsp_bus_o,
  output logic                  rsp_posted_o
);
  logic [NUM_SEG-1:0][BUS_W-1:0] routes;
  logic [BUS_W-1:0]              dec_bus;
  logic                          dec_posted;

  io_route_cfg #(.BUS_W(BUS_W), .LEGACY_BUS(LEGACY_BUS)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .routes_o (routes)
  );

  io_route_decode #(.BUS_W(BUS_W)) u_dec (
    .addr_i    (req_addr_i),
    .write_i   (req_write_i),
    .post_en_i (post_en_i),
    .routes_i  (routes),
    .bus_o     (dec_bus),
    .posted_o  (dec_posted)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_bus_o    <= '0;
      rsp_posted_o <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_bus_o    <= req_valid_i ? dec_bus : '0;
      rsp_posted_o <= req_valid_i && dec_posted;
    end
  end
endmodule

// File: rtl/io_seg_router_chk.sv
module io_seg_router_chk
  import io_route_pkg::*;
#(
  parameter int unsigned BUS_W      = 2,
  parameter int unsigned LEGACY_BUS = 0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [SEG_SEL_W-1:0] cfg_sel_i,
  input logic [BUS_W-1:0]     cfg_rdata_o,
  input logic                 post_en_i,
  input logic                 req_valid_i,
  input logic [IO_ADDR_W-1:0] req_addr_i,
  input logic                 req_write_i,
  input logic                 rsp_valid_o,
  input logic [BUS_W-1:0]     rsp_bus_o,
  input logic                 rsp_posted_o
);
  localparam logic [BUS_W-1:0] LEGACY = BUS_W'(LEGACY_BUS);

  p_rsp_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_posted_o && rsp_bus_o == '0));
  p_seg0_route_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[15:12] == 4'd0) |=> rsp_bus_o == LEGACY);
  p_seg0_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_sel_i == '0 |-> cfg_rdata_o == LEGACY);
  p_low_defer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i < 16'h0100) |=> !rsp_posted_o);
  p_post_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i >= 16'h0100)
      |=> rsp_posted_o == $past(post_en_i));
  p_read_defer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> !rsp_posted_o);
endmodule

bind io_seg_router io_seg_router_chk #(.BUS_W(BUS_W), .LEGACY_BUS(LEGACY_BUS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_sel_i    (cfg_sel_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .post_en_i    (post_en_i),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .req_write_i  (req_write_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_bus_o    (rsp_bus_o),
  .rsp_posted_o (rsp_posted_o)
);

// File: tb/io_seg_router_test.sv
`timescale 1ns/1ps
module io_seg_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [1:0]  cfg_wdata = '0;
  logic [1:0]  cfg_rdata;
  logic        post_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_bus;
  logic        rsp_posted;

  int n_run = 0;
  int n_fail = 0;
  logic [1:0] model [16];

  always #4 clk = ~clk;

  io_seg_router uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .post_en_i(post_en),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_bus_o(rsp_bus), .rsp_posted_o(rsp_posted)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] s, input logic [1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s != 0) model[s] = v;
  endtask

  task automatic read_check(string req, input logic [3:0] s);
    @(negedge clk);
    cfg_sel = s;
    #1 check(req, cfg_rdata, model[s]);
  endtask

  // one request, result checked one edge later
  task automatic req_check(string req, input logic [15:0] a, input logic wr,
                           input logic pen, input logic exp_post);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; post_en = pen;
    @(posedge clk); #1;
    check({req, " valid"}, rsp_valid, 1);
    check({req, " bus"}, rsp_bus, model[a[15:12]]);
    check({req, " posted"}, rsp_posted, exp_post);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", rsp_valid, 0);
    for (int s = 0; s < 16; s++) read_check("R1 reset route", 4'(s));
  endtask

  task automatic t_routes;
    for (int s = 1; s < 16; s++) cfg_write(4'(s), 2'((s * 3 + 1) % 4));
    for (int s = 1; s < 16; s++) read_check("R2 readback", 4'(s));
    for (int s = 1; s < 16; s++) req_check("R2 route", {4'(s), 12'(s * 257)}, 1'b0, 1'b1, 1'b0);
    req_check("R2 0x0FFF seg0", 16'h0FFF, 1'b0, 1'b0, 1'b0);
    req_check("R2 0x1000 seg1", 16'h1000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_seg0;
    cfg_write(4'd0, 2'd3);
    read_check("R3 seg0 readback", 4'd0);
    req_check("R3 seg0 route", 16'h0800, 1'b1, 1'b1, 1'b1);
    req_check("R3 seg0 low route", 16'h0010, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_posting;
    req_check("R4 0x00FF write posting on", 16'h00FF, 1'b1, 1'b1, 1'b0);
    req_check("R4 0x0000 write posting on", 16'h0000, 1'b1, 1'b1, 1'b0);
    req_check("R5 0x0100 write posting on", 16'h0100, 1'b1, 1'b1, 1'b1);
    req_check("R5 0xFFFF write posting on", 16'hFFFF, 1'b1, 1'b1, 1'b1);
    req_check("R5 0x2000 write posting off", 16'h2000, 1'b1, 1'b0, 1'b0);
    req_check("R6 0x3000 read posting on", 16'h3000, 1'b0, 1'b1, 1'b0);
    req_check("R6 0x0100 read posting on", 16'h0100, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_timing;
    logic [1:0] old_v, new_v;
    old_v = model[5];
    new_v = old_v + 2'd1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'd5; cfg_wdata = new_v;
    req_valid = 1'b1; req_addr = 16'h5123; req_write = 1'b0;
    @(posedge clk); #1;
    check("R8 same-cycle uses old route", rsp_bus, old_v);
    @(negedge clk);
    cfg_we = 1'b0;
    model[5] = new_v;
    @(posedge clk); #1;
    check("R8 next-cycle uses new route", rsp_bus, new_v);
    check("R7 back-to-back valid", rsp_valid, 1);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    check("R7 idle valid", rsp_valid, 0);
    check("R7 idle bus", rsp_bus, 0);
    check("R7 idle posted", rsp_posted, 0);
  endtask

  initial begin
    for (int s = 0; s < 16; s++) model[s] = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_routes();
    t_seg0();
    t_posting();
    t_timing();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule